// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a heartbeat line that a processor must toggle regularly. Each qualified change of level on the heartbeat, rising or falling, restarts a timeout counter. If the counter reaches its terminal count before the next qualified change, an active-low fault output drops. It stays low until a kick, a manual reset or a system reset clears the counter. The counter advances on a prescaled tick, so the timeout is `TIMEOUT_TICKS` ticks of `TICK_DIV` clock cycles each.

The heartbeat is asynchronous. It passes through a synchronizer of `SYNC_STAGES` flops and then a width filter. A new level is accepted only after it has held for `MIN_WIDTH` consecutive clocks, which removes short glitches. The supply-OK input overrides the fault output. While supply-OK is low the output is held low, and the counter is held at zero. When supply-OK returns, the output goes high again in the same cycle, with no hold time. An enable input takes the place of sensing a floating heartbeat pin. While the enable is low the counter is held at zero and the block cannot time out. The manual reset, supply-OK and enable inputs are taken to be synchronous to `clk`.

Top module: `wdt_edge_guard`

## Requirements
- R1: After system reset, with supply_ok high, fault_n is high and the timeout count starts from zero.
- R2: With wd_enable and supply_ok high and no kick, fault_n goes low once TIMEOUT_TICKS ticks have elapsed. It stays low while no clear condition occurs.
- R3: A rising heartbeat level change that passes the width filter restarts the count and releases a low fault_n.
- R4: A falling heartbeat level change that passes the width filter restarts the count and releases a low fault_n.
- R5: A heartbeat level held for fewer than MIN_WIDTH consecutive clocks after synchronization produces no kick and does not restart the count. A qualified change yields a kick that lasts exactly one cycle.
- R6: While man_rst_n is low, the count is held at zero and fault_n is high from the following cycle, provided supply_ok is high.
- R7: fault_n is low in any cycle where supply_ok is low, and the count is held at zero. In the cycle supply_ok returns high, fault_n is high, with no stretch.
- R8: While wd_enable is low, the block never times out, and fault_n follows supply_ok alone.
- R9: A kick that arrives in the same cycle in which the count would reach its terminal value wins. The count clears and no fault is raised.
- R10: The count saturates at TIMEOUT_TICKS and never wraps, so a fault that has been raised does not release by itself during a long silence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| man_rst_n | input | 1 | Active-low manual reset, synchronous level |
| supply_ok | input | 1 | High when the monitored supply is above its threshold |
| wd_enable | input | 1 | High to arm the timeout; low stands in for a floating heartbeat |
| heartbeat | input | 1 | Asynchronous processor heartbeat |
| fault_n | output | 1 | Active-low watchdog fault |

## Verification
A regular toggle well inside the timeout window shows that both edge polarities kick the counter. A long silence then shows expiry and the latched, saturating fault. Bursts of one- and two-cycle pulses separate glitches from real kicks: with a working filter these bursts still end in a fault. Manual reset, supply dips and disable periods are applied while a fault is pending. A sweep of kick arrival times across the expiry point then catches the cycle where a kick and the terminal count coincide, and shows which one takes priority.

// File: rtl/wdt_edge_pkg.sv
package wdt_edge_pkg;
   // bits needed to count the values 0 .. n-1, never less than one
   function automatic int bits_for(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wdt_hb_sync.sv
module wdt_hb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/wdt_hb_qualify.sv
module wdt_hb_qualify
   import wdt_edge_pkg::*;
#(
   parameter int MIN_WIDTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic kick
);
   localparam int RUN_W = bits_for(MIN_WIDTH);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_WIDTH - 1);

   logic             accepted;
   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accepted <= 1'b0;
         run      <= '0;
         kick     <= 1'b0;
      end else begin
         kick <= 1'b0;
         if (level_in == accepted) begin
            run <= '0;
         end else if (run == RUN_LAST) begin
            accepted <= level_in;
            run      <= '0;
            kick     <= 1'b1;
         end else begin
            run <= run + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
   import wdt_edge_pkg::*;
#(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_every_clock
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int DIV_W = bits_for(TICK_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] phase;
         assign tick = (phase == DIV_LAST);
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)    phase <= '0;
            else if (tick) phase <= '0;
            else           phase <= phase + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr
   import wdt_edge_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 1600,
   parameter int CNT_W         = bits_for(TIMEOUT_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expired
);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_TICKS);

   assign expired = (count == TERM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (clear)          count <= '0;
      else if (tick && !expired) count <= count + 1'b1;
   end
endmodule

// File: rtl/wdt_edge_guard.sv
module wdt_edge_guard
   import wdt_edge_pkg::*;
#(
   parameter int TICK_DIV      = 50000,
   parameter int TIMEOUT_TICKS = 1600,
   parameter int MIN_WIDTH     = 5,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic man_rst_n,
   input  logic supply_ok,
   input  logic wd_enable,
   input  logic heartbeat,
   output logic fault_n
);
   localparam int CNT_W = bits_for(TIMEOUT_TICKS + 1);

   generate
      if (TICK_DIV < 1)      begin : g_bad_div  $error("TICK_DIV must be at least 1");      end
      if (TIMEOUT_TICKS < 2) begin : g_bad_tmo  $error("TIMEOUT_TICKS must be at least 2"); end
      if (MIN_WIDTH < 2)     begin : g_bad_wid  $error("MIN_WIDTH must be at least 2");     end
      if (SYNC_STAGES < 2)   begin : g_bad_sync $error("SYNC_STAGES must be at least 2");   end
   endgenerate

   logic             hb_sync;
   logic             kick_pulse;
   logic             tick_pulse;
   logic             clear_cnt;
   logic [CNT_W-1:0] tcount;
   logic             expired_flag;

   wdt_hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(heartbeat), .dout(hb_sync));

   wdt_hb_qualify #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
      .clk(clk), .rst_n(rst_n), .level_in(hb_sync), .kick(kick_pulse));

   wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick_pulse));

   // a kick outranks a tick that would reach the terminal count
   assign clear_cnt = kick_pulse | ~man_rst_n | ~supply_ok | ~wd_enable;

   wdt_timeout_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .tick(tick_pulse),
      .count(tcount), .expired(expired_flag));

   assign fault_n = supply_ok & ~expired_flag;
endmodule

// File: rtl/wdt_edge_guard_chk.sv
module wdt_edge_guard_chk #(
   parameter int TIMEOUT_TICKS = 1600,
   parameter int CNT_W         = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             man_rst_n,
   input logic             supply_ok,
   input logic             wd_enable,
   input logic             fault_n,
   input logic             kick,
   input logic             tick,
   input logic [CNT_W-1:0] tcnt,
   input logic             expired
);
   localparam logic [CNT_W-1:0] TERM   = CNT_W'(TIMEOUT_TICKS);
   localparam logic [CNT_W-1:0] BEFORE = CNT_W'(TIMEOUT_TICKS - 1);

   p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt <= TERM);
   p_fault_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !kick && man_rst_n && supply_ok && wd_enable) |=> (expired && !fault_n));
   p_kick_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (tcnt == '0));
   p_kick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !kick);
   p_manual_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!man_rst_n && supply_ok) |=> (tcnt == '0 && fault_n));
   p_supply_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |-> !fault_n);
   p_supply_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && $past(!supply_ok)) |-> fault_n);
   p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_enable |=> !expired);
   p_kick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && tick && tcnt == BEFORE) |=> !expired);
endmodule

bind wdt_edge_guard wdt_edge_guard_chk #(
   .TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .man_rst_n(man_rst_n), .supply_ok(supply_ok),
   .wd_enable(wd_enable), .fault_n(fault_n), .kick(kick_pulse),
   .tick(tick_pulse), .tcnt(tcount), .expired(expired_flag));

// File: tb/wdt_edge_guard_test.sv
module wdt_edge_guard_test;
   localparam int PERIOD = 10;
   localparam int DIV    = 4;
   localparam int TMO    = 10;
   localparam int WID    = 3;
   localparam int STG    = 2;

   logic clk = 1'b0, rst_n = 1'b0, man_rst_n = 1'b1, supply_ok = 1'b1;
   logic wd_enable = 1'b1, heartbeat = 1'b0;
   logic fault_n;

   int errors = 0, checks = 0;
   string tag = "R1";
   bit done = 1'b0;

   wdt_edge_guard #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TMO), .MIN_WIDTH(WID),
                    .SYNC_STAGES(STG)) uut (
      .clk(clk), .rst_n(rst_n), .man_rst_n(man_rst_n), .supply_ok(supply_ok),
      .wd_enable(wd_enable), .heartbeat(heartbeat), .fault_n(fault_n));

   always #(PERIOD/2) clk = ~clk;

   task automatic check(input string t, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: fault_n=%b expected %b at %0t", t, act, exp, $time);
      end
   endtask

   // behavioural reference: queue for the synchronizer, integers elsewhere
   bit m_sync[$];
   int m_lvl, m_run, m_kick, m_phase, m_cnt;
   initial begin
      for (int i = 0; i < STG; i++) m_sync.push_back(1'b0);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STG; i++) m_sync[i] = 1'b0;
         m_lvl = 0; m_run = 0; m_kick = 0; m_phase = 0; m_cnt = 0;
      end else begin
         automatic bit tk = (m_phase == DIV - 1);
         automatic int hb = m_sync[STG-1];
         m_phase = tk ? 0 : m_phase + 1;
         if (m_kick || !man_rst_n || !supply_ok || !wd_enable) m_cnt = 0;
         else if (tk && m_cnt < TMO) m_cnt++;
         m_kick = 0;
         if (hb == m_lvl) m_run = 0;
         else if (m_run == WID - 1) begin m_lvl = hb; m_run = 0; m_kick = 1; end
         else m_run++;
         void'(m_sync.pop_back());
         m_sync.push_front(heartbeat);
      end
      #1;
      if (!done) check(tag, fault_n, supply_ok && (m_cnt != TMO));
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: bench hung, got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(5);
      check("R1", fault_n, 1'b1);

      tag = "R3"; // alternate rising and falling kicks well inside the window
      for (int i = 0; i < 10; i++) begin
         heartbeat = ~heartbeat;
         cyc(20);
      end
      check("R4", fault_n, 1'b1);

      tag = "R2"; // silence: expiry, then saturation
      cyc(80);
      check("R2", fault_n, 1'b0);
      tag = "R10";
      cyc(100);
      check("R10", fault_n, 1'b0);

      tag = "R3"; // heartbeat is low here: a rising kick
      heartbeat = 1'b1;
      cyc(12);
      check("R3", fault_n, 1'b1);

      tag = "R5"; // short pulses only
      for (int i = 0; i < 12; i++) begin
         heartbeat = 1'b0; cyc((i % 2) + 1);
         heartbeat = 1'b1; cyc(8);
      end
      check("R5", fault_n, 1'b0);

      tag = "R4"; // falling kick releases
      heartbeat = 1'b0;
      cyc(12);
      check("R4", fault_n, 1'b1);
      cyc(80);

      tag = "R6";
      man_rst_n = 1'b0;
      cyc(2);
      check("R6", fault_n, 1'b1);
      man_rst_n = 1'b1;
      cyc(20);
      check("R6", fault_n, 1'b1);

      tag = "R7";
      supply_ok = 1'b0;
      #1 check("R7", fault_n, 1'b0);
      cyc(5);
      supply_ok = 1'b1;
      #1 check("R7", fault_n, 1'b1);
      cyc(80);
      supply_ok = 1'b0;
      #1 check("R7", fault_n, 1'b0);
      supply_ok = 1'b1;
      cyc(3);

      tag = "R8";
      wd_enable = 1'b0;
      cyc(150);
      check("R8", fault_n, 1'b1);
      wd_enable = 1'b1;

      tag = "R9"; // kick arrival swept across the expiry cycle
      for (int d = 30; d < 52; d++) begin
         heartbeat = ~heartbeat;
         cyc(d);
      end
      heartbeat = ~heartbeat;
      cyc(12);
      check("R9", fault_n, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule